// File: doc/BRIEF.md
# Chainable Event Counter

Two 8-bit up-counters, a low half and a high half, that either run chained as one 16-bit event counter or run as two independent 8-bit counters. Each count pulse comes from one selectable source: the external event pin, or the system clock divided by 2, 4 or 8. Pin events are synchronized into the clock domain and pass through an edge selector that picks falling edges, rising edges or both. A gate input must be high for any count pulse to reach the counters.

Each half has a run bit and a keep bit. A half counts only when both are set, and it is held at zero while its keep bit is clear. When the chained counter wraps from 0xFFFF to 0x0000, it sets a sticky overflow flag and an interrupt-pending bit, and then keeps counting. The interrupt output follows the pending bit when interrupts are enabled. Software sets up the block and reads it back through a small synchronous write port and a combinational read port.

Top module: `evt_counter_top`

## Requirements
- R1: With the split bit (CTRL bit 0) at 0, the halves form one 16-bit counter. A low half at 0xFF carries into the high half on the next count pulse.
- R2: CTRL bits 2:1 select the count source: 00 = external pin, 01 = clock/2, 10 = clock/4, 11 = clock/8. N consecutive gated cycles produce N/div counts when N is a multiple of div.
- R3: CTRL bits 4:3 select the pin edge: 00 = falling, 01 = rising, 10 = both, 11 = falling. Edges that do not qualify produce no count.
- R4: While gate_in is low, no count pulse reaches either half, whatever the source is doing.
- R5: After reset every register reads 0 and irq is 0. The reset CTRL value selects the external pin with falling-edge sensing.
- R6: In chained mode, the count pulse that arrives at 0xFFFF gives 0x0000, sets STAT bit 0 (overflow) and STAT bit 1 (pending), and later pulses keep counting up.
- R7: irq is 1 exactly when the pending bit is 1 and RUN bit 4 (interrupt enable) is 1.
- R8: RUN bits 0/1 are the low/high run bits and bits 2/3 are the low/high keep bits. A half counts only when both its bits are 1. A half whose keep bit is 0 reads 0x00, even after a write to it.
- R9: Writing 0 to a STAT bit clears it, and writing 1 leaves it unchanged. If an overflow coincides with a clearing write, the bit ends at 1.
- R10: With the split bit at 1, each half counts every pulse on its own, wraps 0xFF to 0x00 with no carry, and never sets the overflow or pending bit.
- R11: Pin events pass through a two-flop synchronizer. Each qualifying edge of a pin level held for at least three clocks adds exactly one count, no later than the fourth rising clock edge after the change.
- R12: Register addresses are 0 = CTRL, 1 = RUN, 2 = STAT, 3 = count low, 4 = count high. The count registers are writable, and a write takes priority over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| evt_pin | input | 1 | External event input, asynchronous |
| gate_in | input | 1 | Count gate, active high |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is a software clear of the status register that lands in the same cycle as a wrap. The bench makes the timing deterministic by using the pin as the source. It preloads 0xFFFF, drives a falling edge at a known negedge, and counts the two synchronizer stages plus the edge-detect stage to find the exact rising edge at which the wrap happens. It then asserts the clearing write for that edge only. Prescaler counts are made independent of the divider's phase by opening the gate for an exact multiple of the division ratio.

// File: rtl/evt_pkg.sv
// Package: shared constants for the chainable event counter.
// Holds register addresses and field positions used by the top level.
package evt_pkg;
    localparam int ADDR_W     = 3;
    localparam int REG_W      = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_RUN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLO  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CHI  = 3'd4;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/evt_prescaler.sv
// Module: evt_prescaler
// Free-running binary divider. tick[k] pulses for one cycle in every
// 2**(k+1) cycles. Assumes the divider runs whether or not the gate is open.
module evt_prescaler #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] tick
);
    logic [STAGES-1:0] div_q;

    // Advance the divider every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_tick
            assign tick[k] = &div_q[k:0];
        end
    endgenerate

    // The fastest tick (clock/2) never fires on two cycles in a row.
    assert_tick_alt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick[0] |=> !tick[0]);
endmodule

// File: rtl/evt_edge_sync.sv
// Module: evt_edge_sync
// Brings the asynchronous event pin through two flops and then produces
// a one-cycle pulse on each qualifying edge. Assumes the pin holds each
// level for at least three clocks and idles at IDLE_LVL.
module evt_edge_sync #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       pulse
);
    import evt_pkg::*;

    logic meta_q, sync_q, prev_q;
    logic rise, fall;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= IDLE_LVL;
            sync_q <= IDLE_LVL;
            prev_q <= IDLE_LVL;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

    // Pick which edges count; the reserved code behaves as falling.
    always_comb begin
        unique case (edge_sel)
            EDGE_RISE: pulse = rise;
            EDGE_BOTH: pulse = rise | fall;
            default:   pulse = fall;
        endcase
    end

    // A pulse needs a synchronized level change one cycle earlier.
    assert_pulse_on_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (sync_q != $past(sync_q)));
    // With pins held three clocks, edges never come back to back.
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/evt_count_core.sv
// Module: evt_count_core
// The two counter halves. In chained mode the low half carries into the
// high half; in split mode each half counts each pulse by itself. The
// keep bit forces a half to zero, loads beat counting, and ovf_evt
// reports the 16-bit wrap for one cycle.
module evt_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pulse,
    input  logic         split,
    input  logic         run_lo,
    input  logic         run_hi,
    input  logic         keep_lo,
    input  logic         keep_hi,
    input  logic         ld_lo,
    input  logic         ld_hi,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic         ovf_evt
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic act_lo, act_hi;
    logic inc_lo, inc_hi, carry;

    assign act_lo  = run_lo & keep_lo;
    assign act_hi  = run_hi & keep_hi;
    assign inc_lo  = pulse & act_lo;
    assign carry   = inc_lo & (cnt_lo == ALL_ONES);
    assign inc_hi  = split ? (pulse & act_hi) : (carry & act_hi);
    assign ovf_evt = ~split & carry & act_hi & (cnt_hi == ALL_ONES) & ~ld_hi;

    // Low half: keep-clear first, then a software load, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n || !keep_lo) cnt_lo <= '0;
        else if (ld_lo)         cnt_lo <= ld_data;
        else if (inc_lo)        cnt_lo <= cnt_lo + 1'b1;
    end

    // High half: same priority, fed by the carry or by the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !keep_hi) cnt_hi <= '0;
        else if (ld_hi)         cnt_hi <= ld_data;
        else if (inc_hi)        cnt_hi <= cnt_hi + 1'b1;
    end

    // Without a pulse or a load, a kept half holds its value.
    assert_hold_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && !ld_lo && keep_lo) |=> (cnt_lo == $past(cnt_lo)));
    // A cleared keep bit leaves the half at zero.
    assert_keep_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !keep_hi |=> (cnt_hi == '0));
    // The wrap event leaves both halves at zero.
    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !ld_lo) |=> (cnt_lo == '0 && cnt_hi == '0));
    // In split mode the wrap event never fires.
    assert_split_no_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        split |-> !ovf_evt);
endmodule

// File: rtl/evt_counter_top.sv
// Module: evt_counter_top
// Chainable event counter: register file, count-source selection, gate,
// and sticky overflow/pending status with interrupt output. Assumes
// gate_in and the register port are synchronous to clk; evt_pin may be
// asynchronous.
module evt_counter_top #(
    parameter int CW         = 8,
    parameter int DIV_STAGES = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [evt_pkg::ADDR_W-1:0] wr_addr,
    input  logic [evt_pkg::REG_W-1:0]  wr_data,
    input  logic [evt_pkg::ADDR_W-1:0] rd_addr,
    output logic [evt_pkg::REG_W-1:0]  rd_data,
    input  logic                      evt_pin,
    input  logic                      gate_in,
    output logic                      irq
);
    import evt_pkg::*;

    localparam int SEL_W = $clog2(DIV_STAGES + 1);

    // Control fields
    logic             split_q;
    logic [SEL_W-1:0] src_q;
    logic [1:0]       edge_q;
    logic             run_lo_q, run_hi_q, keep_lo_q, keep_hi_q, irq_en_q;
    logic             ovf_q, pend_q;

    logic [DIV_STAGES-1:0] tick;
    logic                  pin_pulse, src_pulse, cnt_pulse, ovf_evt;
    logic [CW-1:0]         cnt_lo, cnt_hi;
    logic                  wr_stat, ld_lo, ld_hi;

    assign wr_stat = wr_en && (wr_addr == A_STAT);
    assign ld_lo   = wr_en && (wr_addr == A_CLO);
    assign ld_hi   = wr_en && (wr_addr == A_CHI);

    evt_prescaler #(.STAGES(DIV_STAGES)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    evt_edge_sync #(.IDLE_LVL(1'b1)) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (evt_pin),
        .edge_sel(edge_q),
        .pulse   (pin_pulse)
    );

    // Choose the count source: code 0 is the pin, code k is tick[k-1].
    always_comb begin
        src_pulse = pin_pulse;
        for (int k = 0; k < DIV_STAGES; k++) begin
            if (src_q == SEL_W'(k + 1)) src_pulse = tick[k];
        end
    end

    assign cnt_pulse = src_pulse & gate_in;

    evt_count_core #(.W(CW)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .pulse  (cnt_pulse),
        .split  (split_q),
        .run_lo (run_lo_q),
        .run_hi (run_hi_q),
        .keep_lo(keep_lo_q),
        .keep_hi(keep_hi_q),
        .ld_lo  (ld_lo),
        .ld_hi  (ld_hi),
        .ld_data(wr_data[CW-1:0]),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .ovf_evt(ovf_evt)
    );

    // Control and run registers take software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_q   <= 1'b0;
            src_q     <= '0;
            edge_q    <= 2'b00;
            run_lo_q  <= 1'b0;
            run_hi_q  <= 1'b0;
            keep_lo_q <= 1'b0;
            keep_hi_q <= 1'b0;
            irq_en_q  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                split_q <= wr_data[0];
                src_q   <= wr_data[SEL_W:1];
                edge_q  <= wr_data[SEL_W+2:SEL_W+1];
            end
            if (wr_addr == A_RUN) begin
                run_lo_q  <= wr_data[0];
                run_hi_q  <= wr_data[1];
                keep_lo_q <= wr_data[2];
                keep_hi_q <= wr_data[3];
                irq_en_q  <= wr_data[4];
            end
        end
    end

    // Sticky status: overflow sets, a written 0 clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (ovf_evt)                      ovf_q <= 1'b1;
            else if (wr_stat && !wr_data[0])  ovf_q <= 1'b0;
            if (ovf_evt)                      pend_q <= 1'b1;
            else if (wr_stat && !wr_data[1])  pend_q <= 1'b0;
        end
    end

    assign irq = pend_q & irq_en_q;

    // Read multiplexer over the register map.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: rd_data[SEL_W+2:0] = {edge_q, src_q, split_q};
            A_RUN:  rd_data[4:0]       = {irq_en_q, keep_hi_q, keep_lo_q, run_hi_q, run_lo_q};
            A_STAT: rd_data[1:0]       = {pend_q, ovf_q};
            A_CLO:  rd_data[CW-1:0]    = cnt_lo;
            A_CHI:  rd_data[CW-1:0]    = cnt_hi;
            default: rd_data = '0;
        endcase
    end

    // Status bits only fall through a clearing write.
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_q) && !ovf_q) |-> ($past(wr_stat) && !$past(wr_data[0])));
    // An overflow event always leaves both status bits set.
    assert_ovf_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (ovf_q && pend_q));
    // The interrupt only fires with its enable set.
    assert_irq_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en_q);
    // A closed gate keeps the high half from moving unless it is loaded.
    assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_in && !ld_hi && keep_hi_q) |=> $stable(cnt_hi));
endmodule

// File: tb/sim_evt_counter_top.sv
// Directed bench for evt_counter_top: one task per scenario.
module sim_evt_counter_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       evt_pin = 1'b1;
    logic       gate_in = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evt_counter_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_pin(evt_pin), .gate_in(gate_in), .irq(irq)
    );

    localparam logic [7:0] RUN_ALL = 8'h0F;
    localparam logic [7:0] RUN_IRQ = 8'h1F;

    function automatic logic [7:0] mk_ctrl(input logic split, input logic [1:0] src,
                                           input logic [1:0] edg);
        return {3'b000, edg, src, split};
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] lo, hi;
        rd(3'd3, lo);
        rd(3'd4, hi);
        v = {hi, lo};
    endtask

    task automatic preload(input logic [15:0] v);
        wr(3'd3, v[7:0]);
        wr(3'd4, v[15:8]);
    endtask

    // Open the gate for exactly n rising edges.
    task automatic gate_for(input int n);
        @(negedge clk);
        gate_in = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        gate_in = 1'b0;
    endtask

    // Change the pin and wait until the count has absorbed it.
    task automatic pin_to(input logic v);
        @(negedge clk);
        evt_pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R5", $sformatf("reg %0d after reset", a), d, 0);
        end
        chk("R5", "irq after reset", irq, 0);
    endtask

    task automatic t_default_source;
        int v;
        wr(3'd1, RUN_ALL);
        gate_in = 1'b1;
        pin_to(1'b0);
        rd_cnt(v);
        chk("R5", "falling edge counted by default", v, 1);
        pin_to(1'b1);
        rd_cnt(v);
        chk("R11", "rising edge ignored, one count per edge", v, 1);
        gate_in = 1'b0;
        pin_to(1'b0);
        pin_to(1'b1);
        rd_cnt(v);
        chk("R4", "pin edge with gate low", v, 1);
    endtask

    task automatic t_edges;
        int v;
        preload(16'h0000);
        gate_in = 1'b1;
        wr(3'd0, mk_ctrl(1'b0, 2'b00, 2'b01));
        pin_to(1'b0);
        rd_cnt(v);
        chk("R3", "rising mode, falling edge", v, 0);
        pin_to(1'b1);
        rd_cnt(v);
        chk("R3", "rising mode, rising edge", v, 1);
        wr(3'd0, mk_ctrl(1'b0, 2'b00, 2'b10));
        pin_to(1'b0);
        pin_to(1'b1);
        rd_cnt(v);
        chk("R3", "both-edge mode", v, 3);
        wr(3'd0, mk_ctrl(1'b0, 2'b00, 2'b11));
        pin_to(1'b0);
        pin_to(1'b1);
        rd_cnt(v);
        chk("R3", "reserved code acts as falling", v, 4);
        gate_in = 1'b0;
    endtask

    task automatic t_prescale;
        int v;
        for (int s = 1; s <= 3; s++) begin
            preload(16'h0000);
            wr(3'd0, mk_ctrl(1'b0, 2'(s), 2'b00));
            gate_for(8 << s);
            rd_cnt(v);
            chk("R2", $sformatf("source code %0d, %0d cycles", s, 8 << s), v, 8);
        end
        repeat (40) @(negedge clk);
        rd_cnt(v);
        chk("R4", "divider running, gate low", v, 8);
    endtask

    task automatic t_carry;
        int v;
        wr(3'd0, mk_ctrl(1'b0, 2'b01, 2'b00));
        preload(16'h12FF);
        gate_for(2);
        rd_cnt(v);
        chk("R1", "low half carries into high", v, 16'h1300);
        preload(16'hA5C3);
        rd_cnt(v);
        chk("R12", "count registers writable", v, 16'hA5C3);
    endtask

    task automatic t_overflow;
        int v;
        logic [7:0] s;
        wr(3'd0, mk_ctrl(1'b0, 2'b01, 2'b00));
        preload(16'hFFFF);
        gate_for(2);
        rd_cnt(v);
        chk("R6", "wrap to zero", v, 0);
        rd(3'd2, s);
        chk("R6", "overflow and pending set", s, 3);
        chk("R7", "irq masked while disabled", irq, 0);
        wr(3'd1, RUN_IRQ);
        @(negedge clk);
        chk("R7", "irq with enable and pending", irq, 1);
        gate_for(2);
        rd_cnt(v);
        chk("R6", "counting continues after wrap", v, 1);
        wr(3'd2, 8'h03);
        rd(3'd2, s);
        chk("R9", "writing ones keeps flags", s, 3);
        wr(3'd2, 8'h02);
        rd(3'd2, s);
        chk("R9", "write 0 clears overflow only", s, 2);
        wr(3'd2, 8'h00);
        rd(3'd2, s);
        chk("R9", "write 0 clears pending", s, 0);
        @(negedge clk);
        chk("R7", "irq drops with pending", irq, 0);
        wr(3'd1, RUN_ALL);
    endtask

    task automatic t_ovf_wins;
        logic [7:0] s;
        int v;
        wr(3'd0, mk_ctrl(1'b0, 2'b01, 2'b00));
        preload(16'hFFFF);
        gate_for(2);
        wr(3'd0, mk_ctrl(1'b0, 2'b00, 2'b00));
        preload(16'hFFFF);
        gate_in = 1'b1;
        @(negedge clk);
        evt_pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd2, s);
        chk("R9", "overflow beats same-cycle clear", s, 3);
        rd_cnt(v);
        chk("R6", "wrap via pin edge", v, 0);
        pin_to(1'b1);
        gate_in = 1'b0;
        wr(3'd2, 8'h00);
    endtask

    task automatic t_enables;
        int v;
        logic [7:0] s;
        wr(3'd0, mk_ctrl(1'b0, 2'b01, 2'b00));
        wr(3'd1, 8'h0D);
        preload(16'hFFFF);
        gate_for(2);
        rd_cnt(v);
        chk("R8", "high run off: low wraps, high holds", v, 16'hFF00);
        rd(3'd2, s);
        chk("R8", "no overflow with high run off", s, 0);
        wr(3'd1, 8'h0E);
        gate_for(4);
        rd_cnt(v);
        chk("R8", "low run off holds both halves", v, 16'hFF00);
        wr(3'd1, 8'h0B);
        wr(3'd3, 8'h55);
        rd_cnt(v);
        chk("R8", "keep low off forces zero", v, 16'hFF00);
        wr(3'd1, RUN_ALL);
    endtask

    task automatic t_split;
        int v;
        logic [7:0] s;
        wr(3'd0, mk_ctrl(1'b1, 2'b01, 2'b00));
        preload(16'hFFFF);
        gate_for(2);
        rd_cnt(v);
        chk("R10", "split halves wrap alone", v, 0);
        rd(3'd2, s);
        chk("R10", "split wrap sets no flag", s, 0);
        preload(16'h05FF);
        gate_for(4);
        rd_cnt(v);
        chk("R10", "split halves count each pulse", v, 16'h0701);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_source();
        t_edges();
        t_prescale();
        t_carry();
        t_overflow();
        t_ovf_wins();
        t_enables();
        t_split();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule